// File: doc/BRIEF.md
# Dual-Path Reference Divider

This block divides a local-oscillator signal by a programmed value N and emits one pulse per division period. The pulse feeds the phase comparator of a frequency synthesizer. Each oscillator is given as a tick input. A tick is a one-cycle strobe on the system clock that marks one oscillator edge. Two select bits choose among three paths:
- a high-band path, in which the high-band ticks pass through a divide-by-two stage and then into a wide down-counter;
- a low-band path that feeds the same wide counter directly;
- a low-band path that feeds a narrow divider.

The divisor is checked against the legal range of the selected path. An illegal value raises a flag and holds the output quiet. A divisor written during a period takes effect only at the next terminal count, so no period is cut short or stretched. A reset or a change of path restarts the count from the divisor currently presented.

Top module: `refdiv_top`

## Requirements
- R1: With `band_hi`=1, only `hi_tick` is counted. It passes a divide-by-two stage, so pulses come every 2·N high-band ticks.
- R2: With `band_hi`=0 and `lo_wide`=1, `lo_tick` drives the wide counter directly, and pulses come every N low-band ticks.
- R3: With `band_hi`=0 and `lo_wide`=0, `lo_tick` drives the narrow divider, and pulses come every N low-band ticks.
- R4: `range_err` is 1 in the same cycle whenever the divisor is outside the selected path's legal range. That range is WIDE_MIN..2^DIV_W−1 on both wide-counter paths, and NARROW_MIN..2^NARROW_W−1 on the narrow path (defaults 272..65535 and 4..4095).
- R5: While `range_err` is 1, `div_pulse` stays 0 and no tick is counted. In the first cycle the divisor is legal again, counting restarts from that divisor, and a tick presented in that cycle is not counted.
- R6: A divisor written in the middle of a period does not alter that period. It is loaded at the terminal count, and the following period uses it.
- R7: `div_pulse` is high for exactly one clock cycle. That cycle follows the clock edge that sampled the tick completing the period.
- R8: Ticks on the oscillator input that is not selected have no effect on `div_pulse`.
- R9: Synchronous reset (`rst`=1) clears the divide-by-two stage, loads the counters from the divisor, and holds `div_pulse` at 0. Ticks during reset are not counted, so the first pulse follows exactly one full period after release.
- R10: A change of path selection restarts counting from the divisor, and a tick presented in the cycle of the change is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| hi_tick | input | 1 | High-band oscillator edge strobe |
| lo_tick | input | 1 | Low-band oscillator edge strobe |
| band_hi | input | 1 | 1 selects the high-band path |
| lo_wide | input | 1 | On low band: 1 selects the wide counter, 0 the narrow divider |
| divisor | input | DIV_W | Programmed division value N |
| div_pulse | output | 1 | One-cycle pulse per division period |
| range_err | output | 1 | Divisor outside the legal range of the selected path |

## Verification
The bench builds the block with DIV_W=10, NARROW_W=6, WIDE_MIN=20 and NARROW_MIN=4. This small configuration makes the range flag check exhaustive: every divisor value is tried on all three paths. The narrow divider's whole legal range, including both end values, gets period measurements. The wide paths are sampled in steps up to the top value 1023. The reduced size also keeps reloads mid-period, restarts after a path change, and recovery from an illegal value short enough to follow tick by tick against an arithmetic period model.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;

    typedef enum logic [1:0] {
        PATH_NARROW  = 2'd0,
        PATH_LO_WIDE = 2'd1,
        PATH_HI      = 2'd2
    } path_e;

    typedef struct packed {
        logic restart;
        logic step;
    } ctr_ctl_t;

    function automatic path_e pick_path(input logic band_hi, input logic lo_wide);
        if (band_hi)      return PATH_HI;
        else if (lo_wide) return PATH_LO_WIDE;
        else              return PATH_NARROW;
    endfunction

    function automatic logic div_legal(input path_e p, input logic [31:0] d,
                                       input int narrow_w, input int wide_min,
                                       input int narrow_min);
        if (p == PATH_NARROW)
            return (d >= 32'(narrow_min)) && (d < (32'd1 << narrow_w));
        else
            return d >= 32'(wide_min);
    endfunction

endpackage

// File: rtl/refdiv_halver.sv
module refdiv_halver (
    input  logic clk,
    input  logic clr,
    input  logic tick,
    output logic stroke
);
    logic phase;

    always_ff @(posedge clk) begin
        if (clr)       phase <= 1'b0;
        else if (tick) phase <= ~phase;
    end

    assign stroke = tick & phase;

    // R1
    halver_spacing_chk: assert property (@(posedge clk) disable iff (clr)
        stroke |=> !stroke);

endmodule

// File: rtl/refdiv_count.sv
module refdiv_count #(
    parameter int W = 16
) (
    input  logic                 clk,
    input  refdiv_pkg::ctr_ctl_t ctl,
    input  logic [W-1:0]         load_val,
    output logic                 fire
);
    logic [W-1:0] cnt;
    logic         at_end;

    assign at_end = (cnt == '0) || (cnt == W'(1));

    always_ff @(posedge clk) begin
        if (ctl.restart) begin
            cnt  <= load_val;
            fire <= 1'b0;
        end else if (ctl.step) begin
            if (at_end) begin
                cnt  <= load_val;
                fire <= 1'b1;
            end else begin
                cnt  <= cnt - 1'b1;
                fire <= 1'b0;
            end
        end else begin
            fire <= 1'b0;
        end
    end

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (ctl.restart)
        !ctl.step |=> $stable(cnt));

    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (ctl.restart)
        !ctl.step |=> !fire);

endmodule

// File: rtl/refdiv_top.sv
module refdiv_top #(
    parameter int DIV_W      = 16,
    parameter int NARROW_W   = 12,
    parameter int WIDE_MIN   = 272,
    parameter int NARROW_MIN = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hi_tick,
    input  logic             lo_tick,
    input  logic             band_hi,
    input  logic             lo_wide,
    input  logic [DIV_W-1:0] divisor,
    output logic             div_pulse,
    output logic             range_err
);
    import refdiv_pkg::*;

    localparam int NARROW_TOP = (1 << NARROW_W) - 1;

    path_e    path_w, path_q;
    logic     legal_w, hold_q, restart, path_chg;
    logic     pre_stroke, wide_fire, narrow_fire, sel_tick;
    ctr_ctl_t wide_ctl, narrow_ctl;

    assign path_w    = pick_path(band_hi, lo_wide);
    assign legal_w   = div_legal(path_w, 32'(divisor), NARROW_W, WIDE_MIN, NARROW_MIN);
    assign range_err = !legal_w;

    always_ff @(posedge clk) begin
        path_q <= path_w;
        hold_q <= range_err;
    end

    assign path_chg = (path_w != path_q);
    assign restart  = rst | path_chg | range_err | hold_q;
    assign sel_tick = (path_w == PATH_HI) ? hi_tick : lo_tick;

    refdiv_halver u_halver (
        .clk    (clk),
        .clr    (restart),
        .tick   (hi_tick & (path_w == PATH_HI)),
        .stroke (pre_stroke)
    );

    always_comb begin
        wide_ctl.restart   = restart;
        wide_ctl.step      = (path_w == PATH_HI) ? pre_stroke
                                                 : (lo_tick & (path_w == PATH_LO_WIDE));
        narrow_ctl.restart = restart;
        narrow_ctl.step    = lo_tick & (path_w == PATH_NARROW);
    end

    refdiv_count #(.W(DIV_W)) u_wide (
        .clk      (clk),
        .ctl      (wide_ctl),
        .load_val (divisor),
        .fire     (wide_fire)
    );

    refdiv_count #(.W(NARROW_W)) u_narrow (
        .clk      (clk),
        .ctl      (narrow_ctl),
        .load_val (divisor[NARROW_W-1:0]),
        .fire     (narrow_fire)
    );

    assign div_pulse = wide_fire | narrow_fire;

    // R4
    narrow_range_chk: assert property (@(posedge clk) disable iff (rst)
        (path_w == PATH_NARROW && 32'(divisor) > 32'(NARROW_TOP)) |-> range_err);

    // R5
    err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        range_err |=> !div_pulse);

    // R10
    path_restart_chk: assert property (@(posedge clk) disable iff (rst)
        path_chg |=> !div_pulse);

    // R7
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        div_pulse |=> !div_pulse);

    // R8
    pulse_source_chk: assert property (@(posedge clk) disable iff (rst)
        div_pulse |-> $past(sel_tick));

    // R7
    one_source_chk: assert property (@(posedge clk) disable iff (rst)
        !(wide_fire && narrow_fire));

endmodule

// File: tb/tb_refdiv_top.sv
module tb_refdiv_top;
    localparam int DW = 10, NW = 6, WMIN = 20, NMIN = 4;

    logic clk = 1'b0;
    logic rst = 1'b1, hi_tick = 1'b0, lo_tick = 1'b0, band_hi = 1'b0, lo_wide = 1'b1;
    logic [DW-1:0] divisor = DW'(100);
    logic div_pulse, range_err;

    int compared = 0, mismatched = 0;
    bit finished = 0;

    logic exp_pulse = 1'b0;
    int   tc = 0, per = 0, prev_path = -1;
    bit   prev_leg = 1'b1;

    refdiv_top #(.DIV_W(DW), .NARROW_W(NW), .WIDE_MIN(WMIN), .NARROW_MIN(NMIN)) dut (
        .clk(clk), .rst(rst), .hi_tick(hi_tick), .lo_tick(lo_tick),
        .band_hi(band_hi), .lo_wide(lo_wide), .divisor(divisor),
        .div_pulse(div_pulse), .range_err(range_err)
    );

    always #5 clk = ~clk;

    function automatic bit legal_m(int p, int d);
        if (p == 0) return (d >= NMIN) && (d < (1 << NW));
        return d >= WMIN;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // p: 0 narrow, 1 low wide, 2 high band
    task automatic step(bit r, int p, int d, bit ht, bit lt, string req);
        bit leg, sel;
        int mult;
        @(negedge clk);
        check(div_pulse === exp_pulse, req, int'(div_pulse), int'(exp_pulse));
        rst = r; band_hi = (p == 2); lo_wide = (p == 1);
        divisor = d[DW-1:0]; hi_tick = ht; lo_tick = lt;
        leg  = legal_m(p, d);
        mult = (p == 2) ? 2 : 1;
        exp_pulse = 1'b0;
        if (r || p != prev_path || !leg || !prev_leg) begin
            tc = 0; per = mult * d;
        end else begin
            sel = (p == 2) ? ht : lt;
            if (sel) begin
                tc++;
                if (tc == per) begin
                    exp_pulse = 1'b1; tc = 0; per = mult * d;
                end
            end
        end
        prev_path = p; prev_leg = leg;
    endtask

    task automatic run(int p, int d, int len, string req);
        step(1, p, d, 1, 1, req);
        step(1, p, d, 1, 1, req);
        for (int k = 0; k < len; k++) step(0, p, d, 1, 1, req);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        mismatched++;
        compared++;
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        // R9: reset state and ticks during reset ignored
        step(1, 1, 25, 1, 1, "R9");
        step(1, 1, 25, 1, 1, "R9");
        @(negedge clk);
        check(div_pulse === 1'b0, "R9", int'(div_pulse), 0);
        for (int k = 0; k < 60; k++) step(0, 1, 25, 1, 1, "R9");

        // R4: exhaustive range flag sweep
        for (int p = 0; p < 3; p++)
            for (int d = 0; d < (1 << DW); d++) begin
                step(1, p, d, 0, 0, "R4");
                #1 check(range_err === !legal_m(p, d), "R4", int'(range_err), int'(!legal_m(p, d)));
            end

        // R3: whole narrow legal range
        for (int d = NMIN; d < (1 << NW); d++) run(0, d, 2 * d + 2, "R3");
        // R2: wide low path
        for (int d = WMIN; d < (1 << DW); d += 73) run(1, d, 2 * d + 2, "R2");
        run(1, 1023, 2050, "R2");
        // R1: prescaled high-band path
        for (int d = WMIN; d < (1 << DW); d += 149) run(2, d, 4 * d + 2, "R1");
        run(2, 1023, 4100, "R1");

        // R7: minimum narrow divisor, pulses back to back in spacing
        run(0, 4, 40, "R7");

        // R8: unselected input toggling, selected input sparse
        run(2, 21, 0, "R8");
        for (int k = 0; k < 300; k++) step(0, 2, 21, (k % 3) == 0, 1, "R8");
        run(0, 7, 0, "R8");
        for (int k = 0; k < 100; k++) step(0, 0, 7, 1, (k % 2) == 0, "R8");

        // R6: divisor rewritten mid-period
        run(1, 30, 45, "R6");
        for (int k = 0; k < 100; k++) step(0, 1, 22, 1, 1, "R6");
        run(0, 9, 5, "R6");
        for (int k = 0; k < 40; k++) step(0, 0, 4, 1, 1, "R6");
        run(2, 25, 70, "R6");
        for (int k = 0; k < 120; k++) step(0, 2, 40, 1, 1, "R6");

        // R5: illegal divisors hold the output, then recovery
        run(1, 25, 10, "R5");
        for (int k = 0; k < 50; k++) step(0, 1, 10, 1, 1, "R5");
        @(negedge clk);
        check(range_err === 1'b1, "R5", int'(range_err), 1);
        for (int k = 0; k < 60; k++) step(0, 1, 25, 1, 1, "R5");
        for (int k = 0; k < 20; k++) step(0, 0, 64, 1, 1, "R5");
        for (int k = 0; k < 20; k++) step(0, 0, 3, 1, 1, "R5");
        for (int k = 0; k < 30; k++) step(0, 0, 5, 1, 1, "R5");

        // R10: path changes mid-period
        run(1, 25, 30, "R10");
        for (int k = 0; k < 60; k++) step(0, 0, 25, 1, 1, "R10");
        for (int k = 0; k < 120; k++) step(0, 2, 25, 1, 1, "R10");
        for (int k = 0; k < 60; k++) step(0, 1, 25, 1, 1, "R10");

        step(0, 1, 25, 0, 0, "R10");
        summary();
    end

endmodule